// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry

This block forms the second operand of a data-processing operation from a 32-bit source register value. It applies one of five shift kinds: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. It also produces the shifter carry-out, which is the last bit that left the source value. A separate enable tells the flag logic whether that carry should be written to the carry flag. The shift amount comes either from an immediate field of the instruction or from a register. Only the low byte of a register amount counts.

One result leaves the block per accepted input, registered one cycle after the input is presented with `in_valid` high. The source value passes through the block and is never written back. The surrounding datapath feeds the operand to the ALU. It uses `carry_out` together with `carry_we` to decide the new carry flag. The flag-write rule depends on the operation class: logical operations write the flag only when flag update is requested, test operations always write it, and arithmetic operations never write it.

Top module: `opnd_shifter`

## Requirements
- R1: With `shift_kind` = 0 (logical left) and an amount n from 1 to 31, the result is the source shifted left by n with zeros entering at bit 0, and `carry_out` is source bit 32-n. Codes 5 to 7 of `shift_kind` act as code 0.
- R2: With `shift_kind` = 1 (logical right) and n from 1 to 31, the result is the source shifted right by n with zeros entering at bit 31, and `carry_out` is source bit n-1.
- R3: With `shift_kind` = 2 (arithmetic right) and n from 1 to 31, the vacated top n bits take the value of source bit 31, and `carry_out` is source bit n-1.
- R4: With `shift_kind` = 3 (rotate right) and an amount n that is not a multiple of 32, the result is the source rotated right by n mod 32, and `carry_out` is source bit (n mod 32)-1.
- R5: With `shift_kind` = 4 (one-bit rotate through carry), the result is {`carry_in`, source[31:1]} and `carry_out` is source bit 0. Both amount inputs and the amount select are ignored.
- R6: When `use_reg_amt` = 1 the amount is `reg_amt[7:0]`, and bits 31:8 of `reg_amt` have no effect on the result. When `use_reg_amt` = 0 the amount is `imm_amt`. The immediate ranges an encoder uses are 1..32 for the two right shifts, 0..31 for logical left and 1..31 for rotate.
- R7: An amount of 0, from either source, passes the source through unchanged and makes `carry_out` equal to `carry_in`, for every shift kind except code 4.
- R8: An amount of exactly 32 gives these results. Logical left gives 0 with carry equal to source bit 0. Logical right gives 0 with carry equal to source bit 31. Arithmetic right gives 32 copies of bit 31 with carry equal to bit 31. Rotate leaves the value unchanged with carry equal to bit 31.
- R9: An amount above 32 gives these results. Logical left and logical right give 0 with carry 0. Arithmetic right gives 32 copies of bit 31 with carry equal to bit 31. Rotate uses the amount mod 32, and a non-zero multiple of 32 leaves the value unchanged with carry equal to bit 31.
- R10: `carry_we` is 1 for an accepted input under either of two conditions. The first is `op_class` = 0 (logical) with `flag_upd` = 1. The second is `op_class` = 1 (test), whatever `flag_upd` holds. It is 0 for `op_class` = 2 or 3 (arithmetic).
- R11: `out_valid` repeats `in_valid` one clock later. `opnd_out` and `carry_out` load only when `in_valid` is 1 and otherwise hold. `carry_we` is 0 whenever `out_valid` is 0.
- R12: While `rst_n` is low, `out_valid`, `opnd_out`, `carry_out` and `carry_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| src_val | input | 32 | Source register value to be shifted |
| shift_kind | input | 3 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry |
| use_reg_amt | input | 1 | 1 selects the register amount, 0 the immediate |
| imm_amt | input | 6 | Immediate shift amount |
| reg_amt | input | 32 | Register holding the shift amount, low byte used |
| carry_in | input | 1 | Current carry flag |
| flag_upd | input | 1 | Flag update requested by the operation |
| op_class | input | 2 | 0 logical, 1 test, 2 or 3 arithmetic |
| out_valid | output | 1 | Registered result valid |
| opnd_out | output | 32 | Shifted second operand |
| carry_out | output | 1 | Shifter carry-out |
| carry_we | output | 1 | Carry flag write enable |

## Verification
The bench builds the block at its defaults: a 32-bit data width, an 8-bit amount width and a 6-bit immediate. The 8-bit amount width lets register amounts reach 255. This brings every amount region within reach: zero, 1 to 31, exactly 32, above 32, and rotate amounts of 64, 96 and 224 that wrap to a multiple of 32. The 6-bit immediate can also express 32 and the out-of-range values 0 and 33 to 63, so the immediate and register paths are compared on the same amounts. Random upper bytes on `reg_amt`, and gaps with `in_valid` low, show whether ignored bits or idle cycles disturb the outputs.

// File: rtl/opshf_pkg.sv
// Package: shared encodings for the second-operand shifter.
// Assumes a 3-bit shift-kind code and a 2-bit operation class code.
package opshf_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

    typedef enum logic [1:0] {
        OC_LOGIC = 2'd0,
        OC_TEST  = 2'd1,
        OC_ARITH = 2'd2,
        OC_ARIT2 = 2'd3
    } op_class_e;

endpackage

// File: rtl/opshf_amt_select.sv
// Module: picks the effective shift amount from the immediate field or from
// the low AMT_W bits of the amount register.
// Assumes AMT_W >= IMM_W and AMT_W <= DATA_W.
module opshf_amt_select #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int IMM_W  = 6
) (
    input  logic              use_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] reg_val,
    output logic [AMT_W-1:0]  amt
);

    // Purpose: select the amount source and zero-extend the immediate.
    always_comb begin
        if (use_reg) begin
            amt = reg_val[AMT_W-1:0];
        end else begin
            amt = AMT_W'(imm);
        end
    end

endmodule

// File: rtl/opshf_rotator.sv
// Module: logarithmic right rotator, one mux stage per amount bit.
// Assumes DATA_W is a power of two; the amount is taken modulo DATA_W.
module opshf_rotator #(
    parameter int DATA_W = 32,
    localparam int SHW   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SHW-1:0]    rot,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stage [SHW+1];

    assign stage[0] = din;

    // One stage for each bit of the rotate amount, weight 2**s.
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        // Purpose: rotate right by STEP when amount bit s is set.
        always_comb begin
            if (rot[s]) begin
                stage[s+1] = {stage[s][STEP-1:0], stage[s][DATA_W-1:STEP]};
            end else begin
                stage[s+1] = stage[s];
            end
        end
    end

    assign dout = stage[SHW];

endmodule

// File: rtl/opshf_core.sv
// Module: combinational shift and carry generation for all shift kinds.
// Left shifts use a rotate by the two's complement of the amount, and the
// vacated bits are then masked. Assumes DATA_W is a power of two and that
// AMT_W can hold the value DATA_W.
module opshf_core #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int SHW   = $clog2(DATA_W)
) (
    input  logic [2:0]        kind,
    input  logic [DATA_W-1:0] src,
    input  logic [AMT_W-1:0]  amt,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    import opshf_pkg::*;

    localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

    logic [SHW-1:0]    rot_r_amt;
    logic [SHW-1:0]    rot_l_amt;
    logic [DATA_W-1:0] rot_r;
    logic [DATA_W-1:0] rot_l;
    logic [DATA_W-1:0] keep_r;
    logic [DATA_W-1:0] keep_l;
    logic              amt_zero;
    logic              amt_over;
    logic              sgn;

    assign rot_r_amt = amt[SHW-1:0];
    assign rot_l_amt = '0 - amt[SHW-1:0];

    opshf_rotator #(.DATA_W(DATA_W)) u_rot_r (
        .din  (src),
        .rot  (rot_r_amt),
        .dout (rot_r)
    );

    opshf_rotator #(.DATA_W(DATA_W)) u_rot_l (
        .din  (src),
        .rot  (rot_l_amt),
        .dout (rot_l)
    );

    // Purpose: bit masks that keep only the bits not vacated by the shift.
    always_comb begin
        keep_r = {DATA_W{1'b1}} >> amt;
        keep_l = {DATA_W{1'b1}} << amt;
    end

    assign amt_zero = (amt == '0);
    assign amt_over = (amt > FULL);
    assign sgn      = src[DATA_W-1];

    // Purpose: choose result and carry by kind, amount region and fill rule.
    always_comb begin
        res  = src;
        cout = cin;
        if (kind == SK_RRX) begin
            res  = {cin, src[DATA_W-1:1]};
            cout = src[0];
        end else if (amt_zero) begin
            res  = src;
            cout = cin;
        end else begin
            case (kind)
                SK_LSR: begin
                    if (amt_over) begin
                        res  = '0;
                        cout = 1'b0;
                    end else begin
                        res  = rot_r & keep_r;
                        cout = rot_r[DATA_W-1];
                    end
                end
                SK_ASR: begin
                    if (amt_over) begin
                        res  = {DATA_W{sgn}};
                        cout = sgn;
                    end else begin
                        res  = (rot_r & keep_r) | (~keep_r & {DATA_W{sgn}});
                        cout = rot_r[DATA_W-1];
                    end
                end
                SK_ROR: begin
                    res  = rot_r;
                    cout = rot_r[DATA_W-1];
                end
                default: begin
                    if (amt_over) begin
                        res  = '0;
                        cout = 1'b0;
                    end else begin
                        res  = rot_l & keep_l;
                        cout = rot_l[0];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/opshf_carry_gate.sv
// Module: decides whether the shifter carry may be written to the flag.
// Assumes the operation class code comes straight from decode.
module opshf_carry_gate (
    input  logic [1:0] op_class,
    input  logic       flag_upd,
    output logic       we
);
    import opshf_pkg::*;

    // Purpose: logical ops write on flag update, test ops always, others never.
    always_comb begin
        case (op_class)
            OC_LOGIC: we = flag_upd;
            OC_TEST:  we = 1'b1;
            default:  we = 1'b0;
        endcase
    end

endmodule

// File: rtl/opnd_shifter.sv
// Module: top of the second-operand shifter. It registers the shifted operand,
// the shifter carry and the carry write enable one cycle after a valid input.
// Assumes DATA_W is a power of two and AMT_W can hold DATA_W.
module opnd_shifter #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int IMM_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_val,
    input  logic [2:0]        shift_kind,
    input  logic              use_reg_amt,
    input  logic [IMM_W-1:0]  imm_amt,
    input  logic [DATA_W-1:0] reg_amt,
    input  logic              carry_in,
    input  logic              flag_upd,
    input  logic [1:0]        op_class,
    output logic              out_valid,
    output logic [DATA_W-1:0] opnd_out,
    output logic              carry_out,
    output logic              carry_we
);

    logic [AMT_W-1:0]  eff_amt;
    logic [DATA_W-1:0] shf_res;
    logic              shf_c;
    logic              we_c;

    opshf_amt_select #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_amt (
        .use_reg (use_reg_amt),
        .imm     (imm_amt),
        .reg_val (reg_amt),
        .amt     (eff_amt)
    );

    opshf_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .kind (shift_kind),
        .src  (src_val),
        .amt  (eff_amt),
        .cin  (carry_in),
        .res  (shf_res),
        .cout (shf_c)
    );

    opshf_carry_gate u_gate (
        .op_class (op_class),
        .flag_upd (flag_upd),
        .we       (we_c)
    );

    // Purpose: output stage; data loads on valid, valid and enable follow input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            opnd_out  <= '0;
            carry_out <= 1'b0;
            carry_we  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            carry_we  <= in_valid & we_c;
            if (in_valid) begin
                opnd_out  <= shf_res;
                carry_out <= shf_c;
            end
        end
    end

endmodule

// File: rtl/opshf_checks.sv
// Module: temporal checks on the shifter ports, bound to opnd_shifter.
// Assumes the encodings of opshf_pkg.
module opshf_checks #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] src_val,
    input logic [2:0]        shift_kind,
    input logic              use_reg_amt,
    input logic [IMM_W-1:0]  imm_amt,
    input logic [DATA_W-1:0] reg_amt,
    input logic              carry_in,
    input logic [1:0]        op_class,
    input logic              out_valid,
    input logic [DATA_W-1:0] opnd_out,
    input logic              carry_out,
    input logic              carry_we
);

    logic amt_is_zero;
    assign amt_is_zero = use_reg_amt ? (reg_amt[7:0] == 8'd0) : (imm_amt == '0);

    assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(opnd_out) && $stable(carry_out)));

    assert_idle_no_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !carry_we);

    assert_arith_no_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class[1]) |=> !carry_we);

    assert_test_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 2'd1) |=> carry_we);

    assert_rrx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_kind == 3'd4) |=>
        (opnd_out == {$past(carry_in), $past(src_val[DATA_W-1:1])}
         && carry_out == $past(src_val[0])));

    assert_zero_amt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_kind != 3'd4 && amt_is_zero) |=>
        (opnd_out == $past(src_val) && carry_out == $past(carry_in)));

endmodule

bind opnd_shifter opshf_checks #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .src_val     (src_val),
    .shift_kind  (shift_kind),
    .use_reg_amt (use_reg_amt),
    .imm_amt     (imm_amt),
    .reg_amt     (reg_amt),
    .carry_in    (carry_in),
    .op_class    (op_class),
    .out_valid   (out_valid),
    .opnd_out    (opnd_out),
    .carry_out   (carry_out),
    .carry_we    (carry_we)
);

// File: tb/tb_opnd_shifter.sv
`timescale 1ns/1ps
// Bench: a bit-at-a-time reference model predicts every output on every clock.
module tb_opnd_shifter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src_val = '0;
    logic [2:0]  shift_kind = '0;
    logic        use_reg_amt = 1'b0;
    logic [5:0]  imm_amt = '0;
    logic [31:0] reg_amt = '0;
    logic        carry_in = 1'b0;
    logic        flag_upd = 1'b0;
    logic [1:0]  op_class = '0;
    logic        out_valid;
    logic [31:0] opnd_out;
    logic        carry_out;
    logic        carry_we;

    int total = 0;
    int bad   = 0;

    // Model of the output registers.
    logic        m_valid = 1'b0;
    logic [31:0] m_op    = '0;
    logic        m_c     = 1'b0;
    logic        m_we    = 1'b0;
    string       m_tag   = "R12";

    always #10 clk = ~clk;

    opnd_shifter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .src_val     (src_val),
        .shift_kind  (shift_kind),
        .use_reg_amt (use_reg_amt),
        .imm_amt     (imm_amt),
        .reg_amt     (reg_amt),
        .carry_in    (carry_in),
        .flag_upd    (flag_upd),
        .op_class    (op_class),
        .out_valid   (out_valid),
        .opnd_out    (opnd_out),
        .carry_out   (carry_out),
        .carry_we    (carry_we)
    );

    // Shift one bit at a time; the carry is whatever bit left last.
    function automatic void ref_shift(input logic [31:0] v, input int kind, input int amt,
                                      input logic cin, output logic [31:0] r, output logic c);
        r = v;
        c = cin;
        if (kind == 4) begin
            c = v[0];
            r = {cin, v[31:1]};
            return;
        end
        for (int i = 0; i < amt; i++) begin
            case (kind)
                1: begin c = r[0]; r = r >> 1; end
                2: begin c = r[0]; r = {r[31], r[31:1]}; end
                3: begin c = r[0]; r = {r[0], r[31:1]}; end
                default: begin c = r[31]; r = r << 1; end
            endcase
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs against the model, away from the active edge.
    task automatic compare();
        chk(out_valid === m_valid, m_tag, "out_valid", 32'(out_valid), 32'(m_valid));
        chk(opnd_out === m_op, m_tag, "opnd_out", opnd_out, m_op);
        chk(carry_out === m_c, m_tag, "carry_out", 32'(carry_out), 32'(m_c));
        chk(carry_we === m_we, m_tag, "carry_we", 32'(carry_we), 32'(m_we));
    endtask

    // One clock: check the last result, then present the next input.
    task automatic step(input bit v, input logic [31:0] s, input int kind, input bit ureg,
                        input int imm, input logic [31:0] ra, input bit cin,
                        input bit fu, input int oc, input string tag);
        logic [31:0] r;
        logic        c;
        int          amt;
        @(negedge clk);
        compare();
        in_valid    = v;
        src_val     = s;
        shift_kind  = 3'(kind);
        use_reg_amt = ureg;
        imm_amt     = 6'(imm);
        reg_amt     = ra;
        carry_in    = cin;
        flag_upd    = fu;
        op_class    = 2'(oc);
        amt = ureg ? int'(ra[7:0]) : imm;
        m_valid = v;
        m_tag   = tag;
        if (v) begin
            ref_shift(s, (kind > 4) ? 0 : kind, amt, cin, r, c);
            m_op = r;
            m_c  = c;
            m_we = (oc == 1) || (oc == 0 && fu);
        end else begin
            m_we = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R12: outputs cleared while reset is held.
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        // R1: logical left, immediate.
        step(1, 32'h8000_0001, 0, 0, 1, 0, 0, 1, 0, "R1");
        step(1, 32'h1234_5678, 0, 0, 31, 0, 0, 1, 0, "R1");
        step(1, 32'hF0F0_0F0F, 6, 0, 4, 0, 0, 1, 0, "R1");
        // R2: logical right.
        step(1, 32'hF000_000F, 1, 0, 4, 0, 0, 1, 0, "R2");
        step(1, 32'hFFFF_FFFF, 1, 0, 31, 0, 0, 1, 0, "R2");
        // R3: arithmetic right.
        step(1, 32'h8000_0010, 2, 0, 5, 0, 0, 1, 0, "R3");
        step(1, 32'h7FFF_FFF1, 2, 0, 1, 0, 1, 1, 0, "R3");
        // R4: rotate right.
        step(1, 32'h0000_0001, 3, 0, 1, 0, 0, 1, 0, "R4");
        step(1, 32'hABCD_1234, 3, 0, 31, 0, 0, 1, 0, "R4");
        step(1, 32'hABCD_1234, 3, 1, 0, 32'h0000_0045, 0, 1, 0, "R4");
        // R5: one-bit rotate through carry, amount inputs ignored.
        step(1, 32'h0000_0003, 4, 0, 17, 0, 0, 1, 0, "R5");
        step(1, 32'h0000_0002, 4, 1, 0, 32'hFFFF_FF09, 1, 1, 0, "R5");
        // R6: only the low byte of the register amount counts.
        step(1, 32'hC000_0003, 1, 1, 0, 32'hFFFF_FF03, 0, 1, 0, "R6");
        step(1, 32'hC000_0003, 0, 1, 63, 32'h8000_0102, 0, 1, 0, "R6");
        // R7: amount zero passes through with carry unchanged.
        step(1, 32'hDEAD_BEEF, 0, 0, 0, 0, 1, 1, 0, "R7");
        step(1, 32'hDEAD_BEEF, 2, 1, 9, 32'h0000_0100, 0, 1, 0, "R7");
        step(1, 32'hDEAD_BEEF, 3, 1, 9, 32'h0000_0000, 1, 1, 0, "R7");
        // R8: amount of exactly 32.
        step(1, 32'h0000_0001, 0, 1, 0, 32'd32, 0, 1, 0, "R8");
        step(1, 32'h8000_0000, 1, 0, 32, 0, 0, 1, 0, "R8");
        step(1, 32'h8000_0000, 2, 0, 32, 0, 0, 1, 0, "R8");
        step(1, 32'h8765_4321, 3, 1, 0, 32'd32, 0, 1, 0, "R8");
        // R9: amounts above 32.
        step(1, 32'hFFFF_FFFF, 0, 1, 0, 32'd33, 1, 1, 0, "R9");
        step(1, 32'hFFFF_FFFF, 1, 0, 40, 0, 1, 1, 0, "R9");
        step(1, 32'h8000_0000, 2, 1, 0, 32'd255, 0, 1, 0, "R9");
        step(1, 32'h8765_4321, 3, 1, 0, 32'd64, 0, 1, 0, "R9");
        step(1, 32'h8765_4321, 3, 1, 0, 32'd68, 0, 1, 0, "R9");
        step(1, 32'h0765_4321, 3, 1, 0, 32'd224, 1, 1, 0, "R9");
        // R10: carry write policy by class.
        step(1, 32'h0000_0001, 1, 0, 1, 0, 0, 0, 0, "R10");
        step(1, 32'h0000_0001, 1, 0, 1, 0, 0, 0, 1, "R10");
        step(1, 32'h0000_0001, 1, 0, 1, 0, 0, 1, 2, "R10");
        step(1, 32'h0000_0001, 1, 0, 1, 0, 0, 1, 3, "R10");
        // R11: idle cycles hold data and drop valid and write enable.
        step(0, 32'h5555_5555, 0, 0, 3, 0, 1, 1, 1, "R11");
        step(0, 32'hAAAA_AAAA, 1, 0, 2, 0, 0, 1, 0, "R11");
        step(1, 32'h0F00_00F0, 2, 0, 4, 0, 0, 1, 1, "R11");
        // Mixed random traffic across every kind and amount source.
        for (int i = 0; i < 3000; i++) begin
            int          k;
            bit          ur;
            string       t;
            logic [31:0] ra;
            k  = int'($urandom_range(0, 7));
            ur = 1'($urandom_range(0, 1));
            ra = $urandom();
            if ($urandom_range(0, 3) == 0) ra[7:0] = 8'(32 * $urandom_range(0, 7));
            if (k == 4)           t = "R5";
            else if (ur)          t = "R6";
            else if (k == 3)      t = "R4";
            else if (k == 2)      t = "R3";
            else if (k == 1)      t = "R2";
            else                  t = "R1";
            step(1'($urandom_range(0, 4) != 0), $urandom(), k, ur,
                 int'($urandom_range(0, 63)), ra, 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), t);
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        @(negedge clk);
        compare();
        // R12: reset clears outputs after traffic.
        step(1, 32'hFFFF_FFFF, 4, 0, 0, 0, 1, 1, 1, "R12");
        rst_n = 1'b0;
        @(posedge clk);
        m_valid = 1'b0;
        m_op    = '0;
        m_c     = 1'b0;
        m_we    = 1'b0;
        m_tag   = "R12";
        @(negedge clk);
        compare();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule